// File: doc/BRIEF.md
# Frame-Synchronized Chip-Select Generator

This block produces an active-low select window for a serial capture port that is fed by a converter. Two free-running inputs arrive from outside the chip: a frame-sync strobe near 39 kHz and a data clock near 10 MHz. The block samples both inputs in a faster system clock domain. Each rising edge of frame sync opens a window: the select output goes low and a bit counter clears. The counter then advances on each rising edge of the data clock. After a parameterised number of edges (192 by default, which is 24 eight-bit words) the select output goes high again. After that the data clock is ignored until the next frame-sync rising edge.

Once reset is released, the block needs no per-frame intervention. The select output can therefore gate a capture shifter that expects a real chip-select framing. A window-active flag and a one-cycle frame-done strobe are offered to neighbouring logic. The system clock must run at least four times faster than the data clock, for example 100 MHz or 200 MHz.

Top module: `frame_select_gen`

## Requirements
- R1: While reset is asserted and after it is released, with both inputs held low, `sel_n_o` is 1, `win_active_o` is 0 and `frame_done_o` is 0.
- R2: A rising edge on `frame_sync_i` drives `sel_n_o` to 0 and `win_active_o` to 1. The change appears on the third rising edge of `clk_i` after the input changes: two synchronizer stages plus one state register.
- R3: While the window is open, only rising edges of `data_clk_i` advance the count. Falling edges have no effect.
- R4: When the count reaches `TERM_COUNT` rising edges (default 192), `sel_n_o` returns to 1 and `win_active_o` to 0. This happens on the third `clk_i` edge after the final data-clock rise.
- R5: `frame_done_o` is high for exactly one `clk_i` cycle. That cycle is the one in which `sel_n_o` goes from 0 to 1, and the strobe occurs at no other time.
- R6: While the window is closed, data-clock edges have no effect, and `sel_n_o` stays 1 until the next frame-sync rising edge. Holding `frame_sync_i` high, or lowering it, does not open a window.
- R7: A frame-sync rising edge that arrives while a window is open restarts the window. `sel_n_o` stays 0, and a full `TERM_COUNT` further data-clock rising edges are needed to close it.
- R8: A data-clock rising edge detected in the same system cycle as a frame-sync rising edge does not count toward the new window.
- R9: Correct operation requires `data_clk_i` to stay high for at least 2 `clk_i` cycles and low for at least 2 `clk_i` cycles. Every such rising edge is counted exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x the data-clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_sync_i | input | 1 | Asynchronous frame-sync strobe; its rising edge opens a window |
| data_clk_i | input | 1 | Asynchronous data clock; its rising edges are counted |
| sel_n_o | output | 1 | Active-low select window |
| win_active_o | output | 1 | High while a window is open |
| frame_done_o | output | 1 | One-cycle strobe when a window closes |

## Verification
The assertions take for granted that each external input stays stable long enough for every edge to be seen once after synchronization. The data clock therefore has to hold each level for at least two system cycles, and both inputs have to be low when reset is released. The stimulus meets this by changing the inputs only on falling system-clock edges. Data-clock pulses are never shorter than two cycles high and two cycles low, and some frames use the realistic 20-cycle data-clock period. Coincident edges are produced by raising both inputs on the same falling edge. Because both inputs pass through identical synchronizer chains, the two edges are detected in the same system cycle.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
   typedef enum logic {
      WIN_IDLE = 1'b0,
      WIN_OPEN = 1'b1
   } win_state_e;

   function automatic int cnt_width(input int term);
      return (term > 2) ? $clog2(term) : 1;
   endfunction
endpackage

// File: rtl/fsg_edge_sync.sv
module fsg_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $fatal(1, "fsg_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               chain_q[s] <= 1'b0;
            end else if (s == 0) begin
               chain_q[s] <= async_i;
            end else begin
               chain_q[s] <= chain_q[(s > 0) ? s-1 : 0];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) last_q <= 1'b0;
      else         last_q <= chain_q[STAGES-1];
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/fsg_bit_counter.sv
module fsg_bit_counter #(
   parameter int TERM_COUNT = 192,
   parameter int CNT_W      = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             step_i,
   output logic             last_o,
   output logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(TERM_COUNT - 1);

   logic [CNT_W-1:0] cnt_q;

   assign last_o = step_i && (cnt_q == LAST_VAL);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clear_i || last_o) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count_o = cnt_q;
endmodule

// File: rtl/fsg_window_ctrl.sv
module fsg_window_ctrl
   import fsg_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic open_i,
   input  logic close_i,
   output logic active_o,
   output logic done_o
);
   win_state_e state_q, state_d;
   logic       done_q;

   always_comb begin
      state_d = state_q;
      if (open_i)                               state_d = WIN_OPEN;
      else if (state_q == WIN_OPEN && close_i)  state_d = WIN_IDLE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= WIN_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= (state_q == WIN_OPEN) && !open_i && close_i;
      end
   end

   assign active_o = (state_q == WIN_OPEN);
   assign done_o   = done_q;
endmodule

// File: rtl/frame_select_gen.sv
module frame_select_gen #(
   parameter int TERM_COUNT  = 192,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic frame_sync_i,
   input  logic data_clk_i,
   output logic sel_n_o,
   output logic win_active_o,
   output logic frame_done_o
);
   localparam int CNT_W = fsg_pkg::cnt_width(TERM_COUNT);

   generate
      if (TERM_COUNT < 2) begin : g_bad_term
         $fatal(1, "frame_select_gen: TERM_COUNT must be at least 2");
      end
   endgenerate

   logic             fs_rise;
   logic             dc_rise;
   logic             cnt_step;
   logic             cnt_last;
   logic [CNT_W-1:0] cnt_val;
   logic             active;

   fsg_edge_sync #(.STAGES(SYNC_STAGES)) u_fs_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (frame_sync_i),
      .rise_o  (fs_rise)
   );

   fsg_edge_sync #(.STAGES(SYNC_STAGES)) u_dc_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (data_clk_i),
      .rise_o  (dc_rise)
   );

   // a data-clock rise coinciding with a frame start belongs to no window
   assign cnt_step = active && dc_rise && !fs_rise;

   fsg_bit_counter #(.TERM_COUNT(TERM_COUNT), .CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (fs_rise),
      .step_i  (cnt_step),
      .last_o  (cnt_last),
      .count_o (cnt_val)
   );

   fsg_window_ctrl u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .open_i   (fs_rise),
      .close_i  (cnt_last),
      .active_o (active),
      .done_o   (frame_done_o)
   );

   assign sel_n_o      = ~active;
   assign win_active_o = active;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
   parameter int TERM_COUNT = 192,
   parameter int CNT_W      = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             sel_n_o,
   input logic             win_active_o,
   input logic             frame_done_o,
   input logic             fs_rise,
   input logic             dc_rise,
   input logic [CNT_W-1:0] cnt_val
);
   localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(TERM_COUNT - 1);

   assert_open_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fs_rise |=> (!sel_n_o && win_active_o));

   assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_active_o && dc_rise && !fs_rise && cnt_val != LAST_VAL)
      |=> (cnt_val == CNT_W'($past(cnt_val) + 1'b1)) && !sel_n_o);

   assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_active_o && !dc_rise && !fs_rise) |=> ($stable(cnt_val) && win_active_o));

   assert_close_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_active_o && dc_rise && !fs_rise && cnt_val == LAST_VAL)
      |=> (sel_n_o && !win_active_o));

   assert_done_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_done_o |-> (sel_n_o && !$past(sel_n_o)));

   assert_done_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_done_o |=> !frame_done_o);

   assert_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!win_active_o && !fs_rise) |=> (sel_n_o && !win_active_o && !frame_done_o));

   assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_active_o && fs_rise) |=> (cnt_val == '0 && !sel_n_o && !frame_done_o));

   assert_coincide_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fs_rise && dc_rise) |=> (cnt_val == '0));

   assert_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_val <= LAST_VAL);
endmodule

bind frame_select_gen fsg_checker #(.TERM_COUNT(TERM_COUNT), .CNT_W(CNT_W)) u_fsg_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .sel_n_o      (sel_n_o),
   .win_active_o (win_active_o),
   .frame_done_o (frame_done_o),
   .fs_rise      (fs_rise),
   .dc_rise      (dc_rise),
   .cnt_val      (cnt_val)
);

// File: tb/frame_select_gen_bench.sv
`timescale 1ns/1ps
module frame_select_gen_bench;
   localparam int TERM = 192;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fsync = 1'b0;
   logic dclk = 1'b0;
   logic sel_n, active, done;

   int n_checks = 0;
   int n_fail   = 0;
   int done_cnt = 0;
   int done_bad = 0;
   logic prev_sel = 1'b1;
   logic prev_done = 1'b0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   frame_select_gen #(.TERM_COUNT(TERM)) u_frame_select_gen (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .frame_sync_i (fsync),
      .data_clk_i   (dclk),
      .sel_n_o      (sel_n),
      .win_active_o (active),
      .frame_done_o (done)
   );

   // R5 monitor: strobe must coincide with a 0->1 select transition and last one cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) done_cnt++;
         if (done && !(sel_n && !prev_sel)) done_bad++;
         if (done && prev_done) done_bad++;
         if (!done && sel_n && !prev_sel) done_bad++;
      end
      prev_sel  = sel_n;
      prev_done = done;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic dpulse(input int hi, input int lo);
      dclk = 1'b1; cyc(hi);
      dclk = 1'b0; cyc(lo);
   endtask

   task automatic pulses(input int n, input int hi, input int lo);
      for (int i = 0; i < n; i++) dpulse(hi, lo);
   endtask

   task automatic fs_rise_now();
      fsync = 1'b1; cyc(4);
      fsync = 1'b0; cyc(2);
   endtask

   task automatic t_reset();
      check(sel_n == 1'b1, "R1 sel_n in reset", sel_n, 1);
      check(active == 1'b0, "R1 active in reset", active, 0);
      rst_n = 1'b1; cyc(5);
      check(sel_n == 1'b1 && !active && !done, "R1 after release", sel_n, 1);
   endtask

   task automatic t_open_latency();
      int d0;
      d0 = done_cnt;
      fsync = 1'b1;
      cyc(2);
      check(sel_n == 1'b1, "R2 not yet low after 2 edges", sel_n, 1);
      cyc(1);
      check(sel_n == 1'b0 && active, "R2 low on third edge", sel_n, 0);
      cyc(3); fsync = 1'b0; cyc(2);
      pulses(TERM - 1, 2, 2);
      check(sel_n == 1'b0, "R3 still low after TERM-1 rises (falls not counted)", sel_n, 0);
      dclk = 1'b1; cyc(2);
      check(sel_n == 1'b0, "R4 not yet high 2 edges after last rise", sel_n, 0);
      cyc(1);
      check(sel_n == 1'b1 && !active, "R4 high on third edge after last rise", sel_n, 1);
      dclk = 1'b0; cyc(2);
      check(done_cnt == d0 + 1, "R5 one done strobe", done_cnt - d0, 1);
   endtask

   task automatic t_idle_ignore();
      int d0;
      d0 = done_cnt;
      pulses(300, 2, 2);
      check(sel_n == 1'b1 && !active, "R6 dclk ignored while idle", sel_n, 1);
      fsync = 1'b1; cyc(40);
      check(sel_n == 1'b0, "R6 window opened by rise", sel_n, 0);
      pulses(TERM, 2, 2); cyc(2);
      check(sel_n == 1'b1, "R6 closed after full count", sel_n, 1);
      cyc(50);
      check(sel_n == 1'b1, "R6 fsync held high no retrigger", sel_n, 1);
      fsync = 1'b0; cyc(50);
      check(sel_n == 1'b1 && done_cnt == d0 + 1, "R6 fsync fall no effect", done_cnt - d0, 1);
   endtask

   task automatic t_restart();
      int d0;
      d0 = done_cnt;
      fs_rise_now();
      pulses(100, 2, 2);
      fs_rise_now();
      check(sel_n == 1'b0 && done_cnt == d0, "R7 stays low on restart", sel_n, 0);
      pulses(TERM - 1, 2, 2);
      check(sel_n == 1'b0, "R7 count cleared by restart", sel_n, 0);
      dpulse(2, 2);
      check(sel_n == 1'b1 && done_cnt == d0 + 1, "R7 closes after full fresh count", done_cnt - d0, 1);
   endtask

   task automatic t_coincide();
      fs_rise_now();
      pulses(50, 2, 2);
      fsync = 1'b1; dclk = 1'b1; cyc(4);
      fsync = 1'b0; dclk = 1'b0; cyc(4);
      pulses(TERM - 1, 2, 2);
      check(sel_n == 1'b0, "R8 coincident rise not counted", sel_n, 0);
      dpulse(2, 2);
      check(sel_n == 1'b1, "R8 closes on TERM-th later rise", sel_n, 1);
   endtask

   task automatic t_real_rate();
      int d0;
      d0 = done_cnt;
      for (int f = 0; f < 3; f++) begin
         fs_rise_now();
         pulses(TERM - 1, 10, 10);
         check(sel_n == 1'b0, "R9 10 MHz rate TERM-1 rises", sel_n, 0);
         dpulse(10, 10);
         check(sel_n == 1'b1, "R9 10 MHz rate close", sel_n, 1);
         pulses(20, 10, 10);
      end
      check(done_cnt == d0 + 3, "R9 three frames three strobes", done_cnt - d0, 3);
      pulses(TERM, 2, 3);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         check(done_bad == 0, "R5 strobe aligned and single-cycle", done_bad, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      cyc(3);
      t_reset();
      t_open_latency();
      t_idle_ignore();
      t_restart();
      t_coincide();
      t_real_rate();
      cyc(10);
      summary();
   end

   initial begin
      #(5.0 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
   end
endmodule